// File: doc/BRIEF.md
# Flash Program Command Sequencer

This block sits between a CPU register bus and an on-chip flash array and turns bus writes into program operations. Software first writes a clock-divider register once, then stages one address/data pair by writing into flash address space, writes an opcode into a command register, and launches the staged operation by writing a one to the buffer-ready bit of the status register. The block hands the word to the array over a simple request interface, tracks when the staging buffer is free again and when all work has finished, and refuses any write or launch that breaks the protocol by raising a sticky error flag.

Two opcodes are accepted: a single-word program and a burst program. In burst mode the staging buffer frees up as soon as the array takes the current word, so the next word can be staged and launched while the array is still busy. A programmable boundary register marks the top part of the array as protected: a launch aimed at or above the boundary raises a separate protection flag and never reaches the array. Both error flags are cleared by writing ones to them and block all further commands while set. A behavioural array model with a fixed per-word program time and a combinational read port is included so that results can be seen at the ports.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset buf_empty=1, cmd_done=1, acc_err=0, prot_err=0 and every array word reads all ones.
- R2: A write into flash space (bus_reg_sel=0) before any write to the divider register (bus_reg_sel=1, bus_addr[1:0]=0) sets acc_err and is discarded, so a later launch finds nothing staged.
- R3: A second write into flash space after one has been staged and before it is launched sets acc_err and drops the staged word.
- R4: A write into flash space while buf_empty=0 sets acc_err; the operation already under way still completes.
- R5: Writing the status register (bus_addr[1:0]=2) with bit 7 set launches a staged valid command and clears buf_empty and cmd_done on the next cycle; a launch with nothing staged sets acc_err.
- R6: acc_err is cleared only by a status write with bit 5 set, and prot_err only by one with bit 4 set; while either flag is set, flash writes and launches have no effect.
- R7: The command register (bus_addr[1:0]=1) takes opcode 0x20 for a single program and 0x25 for a burst; a launch with any other opcode sets acc_err and writes nothing.
- R8: After a launch at clock edge T, status flags change no earlier than four cycles later: for a single program buf_empty and cmd_done both rise at edge T+HOLD_CYC+1+PROG_CYC; for a burst buf_empty rises at T+HOLD_CYC+1.
- R9: Programming only clears bits: the addressed word becomes its old value ANDed with the staged data, visible on rd_data for rd_addr.
- R10: With the boundary register (bus_addr[1:0]=3) nonzero, a launch to an address at or above it sets prot_err, leaves buf_empty at 1 and the array unchanged; a zero boundary protects nothing.
- R11: In burst mode a second word can be staged and launched while the first is still programming; cmd_done stays 0 until the array is idle with nothing staged or waiting.
- R12: One divider write after reset is enough for any number of following commands.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus and controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Bus write strobe, one cycle per write |
| bus_reg_sel | input | 1 | 1 selects the register window, 0 selects flash space |
| bus_addr | input | ADDR_W | Flash word address, or register index in bits [1:0] |
| bus_wdata | input | DATA_W | Bus write data |
| rd_addr | input | ADDR_W | Array read address |
| rd_data | output | DATA_W | Array word at rd_addr |
| buf_empty | output | 1 | Staging buffer free for a new command |
| cmd_done | output | 1 | All launched work finished |
| acc_err | output | 1 | Sticky protocol violation flag |
| prot_err | output | 1 | Sticky protection violation flag |

## Verification
The assertions take for granted that bus_we is a single-cycle strobe and that register and flash writes never arrive in the same cycle, so a flag can never be set and cleared at one edge; they also assume the divider write precedes any launch that succeeds. The stimulus issues every bus access through one task that raises bus_we for exactly one cycle between falling edges and waits for cmd_done before starting an unrelated command, apart from the deliberate overlaps used to provoke R4 and R11. Flag timing and array contents are predicted from the opcode, the two latency parameters and a bench-side model of the bit-clearing program rule.

// File: rtl/flcs_pkg.sv
package flcs_pkg;
   localparam int STAT_LAUNCH_BIT = 7;
   localparam int STAT_ACC_BIT    = 5;
   localparam int STAT_PROT_BIT   = 4;

   typedef enum logic [1:0] {
      RSEL_DIV  = 2'd0,
      RSEL_CMD  = 2'd1,
      RSEL_STAT = 2'd2,
      RSEL_PROT = 2'd3
   } rsel_e;

   localparam logic [7:0] OPC_SINGLE = 8'h20;
   localparam logic [7:0] OPC_BURST  = 8'h25;
endpackage

// File: rtl/flcs_prot_cmp.sv
module flcs_prot_cmp #(
   parameter int ADDR_W  = 6,
   parameter bit PROT_EN = 1'b1
) (
   input  logic [ADDR_W-1:0] tgt_addr,
   input  logic [ADDR_W-1:0] bound,
   output logic              hit
);
   generate
      if (PROT_EN) begin : g_cmp
         assign hit = (bound != '0) && (tgt_addr >= bound);
      end else begin : g_off
         assign hit = 1'b0 & (^{tgt_addr, bound});
      end
   endgenerate
endmodule

// File: rtl/flcs_array_stub.sv
module flcs_array_stub #(
   parameter int ADDR_W   = 6,
   parameter int DATA_W   = 8,
   parameter int PROG_CYC = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_data,
   output logic              busy,
   output logic              fin,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data
);
   localparam int DEPTH = 1 << ADDR_W;
   localparam int CNT_W = $clog2(PROG_CYC + 1);

   if (PROG_CYC < 1) begin : g_bad_prog
      $error("PROG_CYC must be at least 1");
   end

   logic [DATA_W-1:0] mem [DEPTH];
   logic [CNT_W-1:0]  cnt;

   assign fin     = busy && (cnt == '0);
   assign rd_data = mem[rd_addr];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy <= 1'b0;
         cnt  <= '0;
         for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
      end else begin
         if (req && !busy) begin
            mem[req_addr] <= mem[req_addr] & req_data;
            busy          <= 1'b1;
            cnt           <= CNT_W'(PROG_CYC - 1);
         end else if (fin) begin
            busy <= 1'b0;
         end else if (busy) begin
            cnt <= cnt - 1'b1;
         end
      end
   end
endmodule

// File: rtl/flcs_ctrl.sv
module flcs_ctrl
   import flcs_pkg::*;
#(
   parameter int ADDR_W   = 6,
   parameter int DATA_W   = 8,
   parameter int HOLD_CYC = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_we,
   input  logic              bus_reg_sel,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic              prot_hit,
   input  logic              arr_busy,
   input  logic              arr_fin,
   output logic              arr_req,
   output logic [ADDR_W-1:0] arr_addr,
   output logic [DATA_W-1:0] arr_data,
   output logic [ADDR_W-1:0] prot_bound,
   output logic              buf_empty,
   output logic              cmd_done,
   output logic              acc_err,
   output logic              prot_err
);
   localparam int HOLD_W = $clog2(HOLD_CYC + 1);

   if (HOLD_CYC < 4) begin : g_bad_hold
      $error("HOLD_CYC must be at least 4");
   end
   if (DATA_W < 8 || DATA_W < ADDR_W) begin : g_bad_width
      $error("DATA_W must be at least 8 and at least ADDR_W");
   end
   if (ADDR_W < 2) begin : g_bad_addr
      $error("ADDR_W must be at least 2");
   end

   logic              div_set, staged, pending, burst_q, inflight_burst;
   logic [7:0]        opcode;
   logic [HOLD_W-1:0] hold_cnt, since_launch;

   logic  reg_wr, fl_wr, stat_wr, err_any, op_ok, launch_req;
   logic  fl_bad, fl_ok, launch_bad, launch_prot, launch_ok;
   rsel_e rsel;

   assign rsel        = rsel_e'(bus_addr[1:0]);
   assign reg_wr      = bus_we && bus_reg_sel;
   assign fl_wr       = bus_we && !bus_reg_sel;
   assign stat_wr     = reg_wr && (rsel == RSEL_STAT);
   assign err_any     = acc_err || prot_err;
   assign op_ok       = (opcode == OPC_SINGLE) || (opcode == OPC_BURST);
   assign launch_req  = stat_wr && bus_wdata[STAT_LAUNCH_BIT];

   assign fl_bad      = fl_wr && !err_any && (!div_set || staged || !buf_empty);
   assign fl_ok       = fl_wr && !err_any && !fl_bad;
   assign launch_bad  = launch_req && !err_any && (!staged || !op_ok);
   assign launch_prot = launch_req && !err_any && staged && op_ok && prot_hit;
   assign launch_ok   = launch_req && !err_any && staged && op_ok && !prot_hit;

   assign arr_req     = pending && (hold_cnt == '0) && !arr_busy;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         div_set        <= 1'b0;
         staged         <= 1'b0;
         pending        <= 1'b0;
         burst_q        <= 1'b0;
         inflight_burst <= 1'b0;
         opcode         <= '0;
         hold_cnt       <= '0;
         since_launch   <= HOLD_W'(HOLD_CYC);
         arr_addr       <= '0;
         arr_data       <= '0;
         prot_bound     <= '0;
         buf_empty      <= 1'b1;
         cmd_done       <= 1'b1;
         acc_err        <= 1'b0;
         prot_err       <= 1'b0;
      end else begin
         if (reg_wr && rsel == RSEL_DIV)                div_set    <= 1'b1;
         if (reg_wr && rsel == RSEL_CMD && !err_any)    opcode     <= bus_wdata[7:0];
         if (reg_wr && rsel == RSEL_PROT)               prot_bound <= bus_wdata[ADDR_W-1:0];
         if (stat_wr && bus_wdata[STAT_ACC_BIT])        acc_err    <= 1'b0;
         if (stat_wr && bus_wdata[STAT_PROT_BIT])       prot_err   <= 1'b0;

         if (fl_bad) begin
            acc_err <= 1'b1;
            staged  <= 1'b0;
         end
         if (fl_ok) begin
            staged   <= 1'b1;
            arr_addr <= bus_addr;
            arr_data <= bus_wdata;
         end
         if (launch_bad) begin
            acc_err <= 1'b1;
            staged  <= 1'b0;
         end
         if (launch_prot) begin
            prot_err <= 1'b1;
            staged   <= 1'b0;
         end

         if (pending && hold_cnt != '0) hold_cnt <= hold_cnt - 1'b1;
         if (since_launch != HOLD_W'(HOLD_CYC)) since_launch <= since_launch + 1'b1;

         if (arr_req) begin
            pending        <= 1'b0;
            inflight_burst <= burst_q;
            if (burst_q) buf_empty <= 1'b1;
         end
         if (arr_fin) begin
            if (!inflight_burst) buf_empty <= 1'b1;
            if (!pending)        cmd_done  <= 1'b1;
         end

         if (launch_ok) begin
            staged       <= 1'b0;
            pending      <= 1'b1;
            hold_cnt     <= HOLD_W'(HOLD_CYC);
            since_launch <= '0;
            burst_q      <= (opcode == OPC_BURST);
            buf_empty    <= 1'b0;
            cmd_done     <= 1'b0;
         end
      end
   end

   AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(buf_empty) || $rose(cmd_done)) |-> (since_launch == HOLD_W'(HOLD_CYC))); // R8
   AST_ACC_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_err && !(stat_wr && bus_wdata[STAT_ACC_BIT])) |=> acc_err); // R6
   AST_LAUNCH_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(buf_empty) |-> $past(!acc_err && !prot_err && div_set)); // R6
   AST_DONE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_done |-> (buf_empty && !arr_busy)); // R11
   AST_PROT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(prot_err) |-> (buf_empty && !pending)); // R10
endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq #(
   parameter int ADDR_W   = 6,
   parameter int DATA_W   = 8,
   parameter int PROG_CYC = 3,
   parameter int HOLD_CYC = 4,
   parameter bit PROT_EN  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_we,
   input  logic              bus_reg_sel,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   output logic              buf_empty,
   output logic              cmd_done,
   output logic              acc_err,
   output logic              prot_err
);
   logic              arr_req, arr_busy, arr_fin, prot_hit;
   logic [ADDR_W-1:0] arr_addr, prot_bound;
   logic [DATA_W-1:0] arr_data;

   flcs_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .HOLD_CYC(HOLD_CYC)) ctrl_i (
      .clk(clk), .rst_n(rst_n),
      .bus_we(bus_we), .bus_reg_sel(bus_reg_sel), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .prot_hit(prot_hit), .arr_busy(arr_busy), .arr_fin(arr_fin),
      .arr_req(arr_req), .arr_addr(arr_addr), .arr_data(arr_data), .prot_bound(prot_bound),
      .buf_empty(buf_empty), .cmd_done(cmd_done), .acc_err(acc_err), .prot_err(prot_err)
   );

   flcs_prot_cmp #(.ADDR_W(ADDR_W), .PROT_EN(PROT_EN)) prot_i (
      .tgt_addr(arr_addr), .bound(prot_bound), .hit(prot_hit)
   );

   flcs_array_stub #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PROG_CYC(PROG_CYC)) array_i (
      .clk(clk), .rst_n(rst_n),
      .req(arr_req), .req_addr(arr_addr), .req_data(arr_data),
      .busy(arr_busy), .fin(arr_fin),
      .rd_addr(rd_addr), .rd_data(rd_data)
   );
endmodule

// File: tb/flash_cmd_seq_tb.sv
module flash_cmd_seq_tb_top;
   localparam int AW = 6;
   localparam int DW = 8;
   localparam int PC = 3;
   localparam int HC = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bus_we = 1'b0;
   logic          bus_reg_sel = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic [DW-1:0] bus_wdata = '0;
   logic [AW-1:0] rd_addr = '0;
   logic [DW-1:0] rd_data;
   logic          buf_empty, cmd_done, acc_err, prot_err;

   int  n_run = 0;
   int  n_fail = 0;
   bit  finished = 1'b0;
   logic [DW-1:0] model [1 << AW];

   always #10 clk = ~clk;

   flash_cmd_seq #(.ADDR_W(AW), .DATA_W(DW), .PROG_CYC(PC), .HOLD_CYC(HC)) dut_i (
      .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_reg_sel(bus_reg_sel),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .rd_addr(rd_addr), .rd_data(rd_data),
      .buf_empty(buf_empty), .cmd_done(cmd_done), .acc_err(acc_err), .prot_err(prot_err)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic bus_wr(input logic sel, input logic [AW-1:0] a, input logic [DW-1:0] d);
      @(negedge clk);
      bus_we = 1'b1; bus_reg_sel = sel; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_we = 1'b0; bus_reg_sel = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic mem_chk(input string tag, input logic [AW-1:0] a);
      rd_addr = a;
      #1;
      chk(tag, rd_data, model[a]);
   endtask

   task automatic wait_done();
      for (int i = 0; i < 60 && !cmd_done; i++) @(negedge clk);
   endtask

   task automatic clr_err();
      bus_wr(1'b1, 2, 8'h30);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      for (int i = 0; i < (1 << AW); i++) model[i] = '1;

      // R1 reset state
      chk("R1 buf_empty", buf_empty, 1);
      chk("R1 cmd_done", cmd_done, 1);
      chk("R1 acc_err", acc_err, 0);
      chk("R1 prot_err", prot_err, 0);
      mem_chk("R1 mem0", 0);
      mem_chk("R1 mem63", 63);

      // R2 flash write before divider
      bus_wr(1'b0, 5, 8'h00);
      chk("R2 acc_err set", acc_err, 1);
      clr_err();
      chk("R6 acc_err cleared", acc_err, 0);
      bus_wr(1'b1, 1, 8'h20);
      bus_wr(1'b1, 2, 8'h80);
      chk("R2 R5 launch with nothing staged", acc_err, 1);
      mem_chk("R2 mem unchanged", 5);
      clr_err();

      // R12 single divider write
      bus_wr(1'b1, 0, 8'h07);

      // R6 error blocks and is write-one-to-clear
      bus_wr(1'b1, 2, 8'h80);
      chk("R5 empty launch sets acc_err", acc_err, 1);
      bus_wr(1'b0, 6, 8'h00);
      bus_wr(1'b1, 2, 8'h80);
      idle(HC + PC + 2);
      chk("R6 blocked launch buf_empty", buf_empty, 1);
      mem_chk("R6 blocked mem", 6);
      bus_wr(1'b1, 2, 8'h00);
      chk("R6 zero write keeps acc_err", acc_err, 1);
      bus_wr(1'b1, 2, 8'h20);
      chk("R6 clear", acc_err, 0);

      // R9 R12 R8 exhaustive single programs
      for (int a = 0; a < (1 << AW); a++) begin
         logic [DW-1:0] d;
         d = DW'((a * 37) ^ 8'h5A);
         bus_wr(1'b0, AW'(a), d);
         bus_wr(1'b1, 1, 8'h20);
         bus_wr(1'b1, 2, 8'h80);
         chk("R5 launch clears buf_empty", buf_empty, 0);
         chk("R5 launch clears cmd_done", cmd_done, 0);
         idle(HC + PC);
         chk("R8 single not yet ready", buf_empty, 0);
         idle(1);
         chk("R8 single buf_empty", buf_empty, 1);
         chk("R8 single cmd_done", cmd_done, 1);
         chk("R12 no acc_err", acc_err, 0);
         model[a] = model[a] & d;
         mem_chk("R9 programmed word", AW'(a));
      end

      // R9 second program ANDs
      bus_wr(1'b0, 3, 8'h0F);
      bus_wr(1'b1, 2, 8'h80);
      wait_done();
      model[3] = model[3] & 8'h0F;
      mem_chk("R9 and rule", 3);

      // R3 double stage
      bus_wr(1'b0, 10, 8'h00);
      bus_wr(1'b0, 11, 8'h00);
      chk("R3 second write", acc_err, 1);
      clr_err();
      bus_wr(1'b1, 2, 8'h80);
      chk("R3 stage dropped", acc_err, 1);
      mem_chk("R3 mem10", 10);
      mem_chk("R3 mem11", 11);
      clr_err();

      // R4 write while busy
      bus_wr(1'b0, 12, 8'h00);
      bus_wr(1'b1, 2, 8'h80);
      bus_wr(1'b0, 13, 8'h00);
      chk("R4 write while not empty", acc_err, 1);
      wait_done();
      model[12] = 8'h00;
      mem_chk("R4 in-flight completes", 12);
      mem_chk("R4 rejected word", 13);
      clr_err();

      // R7 bad opcode
      bus_wr(1'b0, 14, 8'h00);
      bus_wr(1'b1, 1, 8'h33);
      bus_wr(1'b1, 2, 8'h80);
      chk("R7 bad opcode", acc_err, 1);
      chk("R7 buf_empty", buf_empty, 1);
      idle(HC + PC + 2);
      mem_chk("R7 no write", 14);
      clr_err();

      // R8 R11 burst
      bus_wr(1'b0, 20, 8'h11);
      bus_wr(1'b1, 1, 8'h25);
      bus_wr(1'b1, 2, 8'h80);
      idle(HC);
      chk("R8 burst early", buf_empty, 0);
      idle(1);
      chk("R8 burst buf_empty", buf_empty, 1);
      chk("R11 burst not done", cmd_done, 0);
      bus_wr(1'b0, 21, 8'h22);
      bus_wr(1'b1, 2, 8'h80);
      chk("R11 second launch ok", acc_err, 0);
      chk("R11 second buf_empty", buf_empty, 0);
      idle(1);
      chk("R11 done held while queued", cmd_done, 0);
      idle(HC - 1);
      chk("R11 second early", buf_empty, 0);
      idle(1);
      chk("R11 second buf_empty", buf_empty, 1);
      idle(PC - 1);
      chk("R11 done not yet", cmd_done, 0);
      idle(1);
      chk("R11 done", cmd_done, 1);
      model[20] = model[20] & 8'h11;
      model[21] = model[21] & 8'h22;
      mem_chk("R11 word20", 20);
      mem_chk("R11 word21", 21);

      // R10 protection sweep
      bus_wr(1'b1, 1, 8'h20);
      bus_wr(1'b1, 3, 8'd48);
      for (int a = 40; a < 64; a++) begin
         bit hit;
         hit = (a >= 48);
         bus_wr(1'b0, AW'(a), 8'h00);
         bus_wr(1'b1, 2, 8'h80);
         chk("R10 prot_err", prot_err, 32'(hit));
         chk("R10 buf_empty", buf_empty, 32'(hit));
         if (hit) begin
            bus_wr(1'b0, AW'(a), 8'h00);
            chk("R10 prot_err blocks", acc_err, 0);
            bus_wr(1'b1, 2, 8'h10);
            chk("R6 prot_err cleared", prot_err, 0);
         end else begin
            wait_done();
            model[a] = 8'h00;
         end
         mem_chk("R10 word", AW'(a));
      end
      bus_wr(1'b1, 3, 8'd0);
      bus_wr(1'b0, 63, 8'h00);
      bus_wr(1'b1, 2, 8'h80);
      chk("R10 zero bound", prot_err, 0);
      wait_done();
      model[63] = 8'h00;
      mem_chk("R10 zero bound word", 63);

      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule